// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller gathers a bank of level-sensitive interrupt request lines, filters them through a per-source mask and a single mask-all bit, and selects one winner by fixed index order. The lowest-numbered pending and unmasked source wins. The winner is offered to the processor as a request line with a vector number beside it. Each source has a vector of its own: a configurable base plus the source number, with sources counted from 1.

The processor can claim the winning vector in two ways. It can pulse a hardware acknowledge strobe, which returns the vector on a dedicated output for exactly one cycle. It can also read the acknowledge register through the small register port. When nothing is eligible, both paths return a reserved spurious vector. An acknowledge never clears a request; the peripheral that raised it must drop its line.

A wake-up output is built from gates only. It reports an eligible request even while the block's clock is stopped, so it can restart a gated clock domain.

Top module: `vic_top`

## Requirements
- R1: After reset every individual mask bit reads 1, the mask-all bit (control register bit 0) reads 1, and irq_o, ack_vld_o and wake_o are 0.
- R2: Source k, driven on irq_i bit k-1 for k in 1..N_SRC, is reported as vector VEC_BASE+k (65..72 with defaults).
- R3: When several eligible sources are pending, the one with the lowest number wins.
- R4: A source whose mask bit (register address 0, bit k-1) is 1 is never selected and does not raise wake_o.
- R5: While the mask-all bit (address 1, bit 0) is 1, no source is selected and wake_o stays 0, whatever the individual mask bits hold.
- R6: A cycle with hw_ack_i high at a clock edge makes ack_vld_o high on the following cycle, with ack_vec_o holding the winner at that edge; ack_vld_o is low after any edge at which hw_ack_i was low.
- R7: A read of address 3 returns the winner's vector on reg_rdata_o one cycle after the read, zero-extended.
- R8: With no eligible source, both acknowledge paths return SPUR_VEC (24 with defaults).
- R9: wake_o is the OR of the eligible requests, formed without any register, and follows irq_i while the clock is stopped.
- R10: irq_o and irq_vec_o are registered: after each edge, irq_o shows whether an eligible request existed at that edge, and irq_vec_o shows its vector.
- R11: Neither acknowledge clears anything: the raw request lines stay readable at address 2, and wake_o stays high until irq_i drops.
- R12: Writes to addresses 2 and 3 have no effect; addresses 0 and 1 read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Level request lines, bit k-1 is source k |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | 0 mask, 1 control, 2 raw pending, 3 acknowledge |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| hw_ack_i | input | 1 | Hardware acknowledge strobe |
| ack_vld_o | output | 1 | One-cycle hardware acknowledge response |
| ack_vec_o | output | VEC_W | Vector returned by hardware acknowledge |
| irq_o | output | 1 | Registered interrupt request to the core |
| irq_vec_o | output | VEC_W | Vector of the current winner |
| wake_o | output | 1 | Combinational wake-up request |

## Verification
A hardware acknowledge strobe and a software read of the acknowledge register can occur in the same cycle. Both must report the same winner, because they sample one arbitration result. The bench raises hw_ack_i and a read of address 3 in one cycle and pushes the expected vector onto two separate queues. The monitor then compares ack_vec_o and reg_rdata_o on the same sampling edge. This is done for a real winner and for the spurious case.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_PEND = 2'd2,
    SEL_IACK = 2'd3
  } vic_sel_e;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 8,
  localparam int SRC_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [SRC_W-1:0] num_o
);
  always_comb begin
    hit_o = 1'b0;
    num_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        num_o = SRC_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [VEC_W-1:0]  win_vec_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              mask_all_o
);
  vic_sel_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel = vic_sel_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '1;
      mask_all_o <= 1'b1;
    end else if (reg_en_i && reg_we_i) begin
      if (sel == SEL_MASK) mask_o     <= reg_wdata_i[N_SRC-1:0];
      if (sel == SEL_CTRL) mask_all_o <= reg_wdata_i[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rd_mux = DATA_W'(mask_o);
      SEL_CTRL: rd_mux = DATA_W'(mask_all_o);
      SEL_PEND: rd_mux = DATA_W'(irq_i);
      SEL_IACK: rd_mux = DATA_W'(win_vec_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    reg_rdata_o <= '0;
    else if (reg_en_i && !reg_we_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/vic_ack.sv
module vic_ack #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [VEC_W-1:0] win_vec_i,
  input  logic             hw_ack_i,
  output logic             ack_vld_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o <= 1'b0;
      ack_vec_o <= '0;
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      ack_vld_o <= hw_ack_i;
      if (hw_ack_i) ack_vec_o <= win_vec_i;
      irq_o     <= hit_i;
      irq_vec_o <= win_vec_i;
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int N_SRC    = 8,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              hw_ack_i,
  output logic              ack_vld_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              wake_o
);
  localparam int SRC_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0] mask;
  logic             mask_all;
  logic [N_SRC-1:0] elig;
  logic             hit;
  logic [SRC_W-1:0] num;
  logic [VEC_W-1:0] win_vec;

  // eligibility and wake path stay free of registers
  assign elig    = irq_i & ~mask & {N_SRC{~mask_all}};
  assign wake_o  = |elig;
  assign win_vec = hit ? VEC_W'(VEC_BASE) + VEC_W'(num) : VEC_W'(SPUR_VEC);

  vic_prio #(.N_SRC(N_SRC)) u_prio (
    .req_i (elig),
    .hit_o (hit),
    .num_o (num)
  );

  vic_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .win_vec_i   (win_vec),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .mask_o      (mask),
    .mask_all_o  (mask_all)
  );

  vic_ack #(.VEC_W(VEC_W)) u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .win_vec_i (win_vec),
    .hw_ack_i  (hw_ack_i),
    .ack_vld_o (ack_vld_o),
    .ack_vec_o (ack_vec_o),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o)
  );
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] irq_i,
  input logic             hw_ack_i,
  input logic             ack_vld_o,
  input logic [VEC_W-1:0] ack_vec_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic             mask_all
);
  p_ack_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_ack_i |=> ack_vld_o);
  p_ack_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_ack_i |=> !ack_vld_o);
  p_vec_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> (ack_vec_o == VEC_W'(SPUR_VEC)) ||
                  ((ack_vec_o > VEC_W'(VEC_BASE)) && (ack_vec_o <= VEC_W'(VEC_BASE + N_SRC))));
  p_spur_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_ack_i && !wake_o) |=> (ack_vec_o == VEC_W'(SPUR_VEC)));
  p_mask_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_all |-> !wake_o);
  p_wake_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (irq_i != '0));
  p_irq_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> irq_o);
  p_irq_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_o |=> !irq_o);
endmodule

bind vic_top vic_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .hw_ack_i  (hw_ack_i),
  .ack_vld_o (ack_vld_o),
  .ack_vec_o (ack_vec_o),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .mask_all  (mask_all)
);

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  localparam int N = 8;
  localparam int DW = 32;
  localparam int VW = 8;
  localparam int BASE = 64;
  localparam int SPUR = 24;

  logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic reg_en = 1'b0, reg_we = 1'b0, hw_ack = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic ack_vld, irq_o, wake;
  logic [VW-1:0] ack_vec, irq_vec;

  int n_cmp = 0, n_bad = 0;
  logic rd_seen = 1'b0;
  logic [N-1:0] sh_mask = '1;
  logic sh_all = 1'b1;
  int ack_q[$];  string ack_t[$];
  int rd_q[$];   string rd_t[$];

  initial forever #2.5 clk = clk_en ? ~clk : clk;

  vic_top i_vic_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .hw_ack_i(hw_ack), .ack_vld_o(ack_vld), .ack_vec_o(ack_vec),
    .irq_o(irq_o), .irq_vec_o(irq_vec), .wake_o(wake)
  );

  function automatic int exp_vec(logic [N-1:0] r, logic [N-1:0] m, logic all);
    if (all) return SPUR;
    for (int i = 0; i < N; i++) if (r[i] && !m[i]) return BASE + i + 1;
    return SPUR;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= reg_en && !reg_we;

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (ack_vld) begin
      if (ack_q.size() == 0) check("R6 unexpected ack", 1, 0);
      else check(ack_t.pop_front(), ack_vec, ack_q.pop_front());
    end
    if (rd_seen) begin
      if (rd_q.size() == 0) check("R7 unexpected read", 1, 0);
      else check(rd_t.pop_front(), reg_rdata, rd_q.pop_front());
    end
  end

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) sh_mask = d[N-1:0];
    if (a == 2'd1) sh_all = d[0];
    @(posedge clk); #1;
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    rd_q.push_back(exp); rd_t.push_back(tag);
    @(posedge clk); #1;
    reg_en = 1'b0;
  endtask

  task automatic hack(string tag);
    @(posedge clk); #1;
    hw_ack = 1'b1;
    ack_q.push_back(exp_vec(irq, sh_mask, sh_all)); ack_t.push_back(tag);
    @(posedge clk); #1;
    hw_ack = 1'b0;
  endtask

  task automatic both(string tag);
    @(posedge clk); #1;
    hw_ack = 1'b1; reg_en = 1'b1; reg_we = 1'b0; reg_addr = 2'd3;
    ack_q.push_back(exp_vec(irq, sh_mask, sh_all)); ack_t.push_back({tag, " hw"});
    rd_q.push_back(exp_vec(irq, sh_mask, sh_all));  rd_t.push_back({tag, " sw"});
    @(posedge clk); #1;
    hw_ack = 1'b0; reg_en = 1'b0;
  endtask

  task automatic set_irq(logic [N-1:0] v);
    @(posedge clk); #1;
    irq = v;
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    if (ack_q.size() != 0) check("R6 missing ack", ack_q.size(), 0);
    if (rd_q.size() != 0)  check("R7 missing read", rd_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_o", irq_o, 0);
    check("R1 ack_vld", ack_vld, 0);
    check("R1 wake", wake, 0);
    rd(2'd0, 8'hFF, "R1 mask reset");
    rd(2'd1, 1, "R1 mask-all reset");

    // masked request: spurious, no wake
    set_irq(8'b0000_0100);
    #1 check("R4 wake while masked", wake, 0);
    hack("R8 spurious while masked");
    wr(2'd0, 0);
    #1 check("R5 mask-all blocks", wake, 0);
    hack("R5 ack under mask-all");
    rd(2'd3, SPUR, "R5 sw ack under mask-all");

    wr(2'd1, 0);
    #1 check("R9 wake on eligible", wake, 1);
    hack("R6 R2 hw ack source 3");
    @(negedge clk);
    check("R10 irq_o", irq_o, 1);
    check("R10 irq_vec", irq_vec, BASE + 3);

    // every source alone
    for (int i = 0; i < N; i++) begin
      set_irq(N'(1) << i);
      rd(2'd3, BASE + i + 1, "R2 per-source vector");
    end

    set_irq(8'b1010_0100);
    hack("R3 lowest wins");
    wr(2'd0, 8'b0000_0100);
    rd(2'd3, BASE + 6, "R4 R7 masked source skipped");
    both("R7 concurrent ack");
    rd(2'd2, 8'b1010_0100, "R11 pending kept after ack");
    #1 check("R11 wake held", wake, 1);

    // stopped clock
    @(negedge clk); clk_en = 1'b0;
    #20 irq = '0;
    #1 check("R9 wake drops, clock stopped", wake, 0);
    #10 irq = 8'b0000_0001;
    #1 check("R9 wake rises, clock stopped", wake, 1);
    #10 clk_en = 1'b1;

    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, 8'b0000_0100, "R12 mask unchanged");
    rd(2'd1, 0, "R12 ctrl unchanged");
    wr(2'd0, 8'h5A);
    rd(2'd0, 8'h5A, "R12 mask readback");

    set_irq('0);
    both("R8 concurrent spurious");
    @(negedge clk);
    check("R10 irq_o low", irq_o, 0);
    wr(2'd1, 1);
    set_irq(8'hFF);
    #1 check("R5 mask-all again", wake, 0);
    hack("R5 spurious under mask-all");
    finish_run();
  end
endmodule